// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Interrupt and Automatic RTS

This block buffers bytes that arrive from a serial receiver until the CPU takes them. It runs in one of three capacities: a single holding register when queueing is switched off, a 16-entry queue, or a 64-entry queue. A 2-bit selector picks a fill threshold from a table that depends on the capacity in use. The interrupt output is high whenever the fill count is at or above that threshold.

When automatic flow control is on, the block drives an active-low request-to-send output. The output goes inactive (high) once the queue reaches the threshold, and it stays inactive until the CPU has drained the queue to zero. Bytes that arrive while the output is inactive are still stored until the queue is full. After that, further bytes are dropped and a sticky overflow flag records the loss. Software clears the flag by reading the status.

The receiver is connected to the write port. The CPU reads the oldest byte from `rd_data_o` and removes it with `rd_en_i`. It polls `empty_o` after each removal to find out whether more bytes are waiting.

Top module: `rx_fifo_flow`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, ovf_o is 0, trig_irq_o is 0 and rts_no is 0.
- R2: Bytes leave in arrival order. While the queue is not empty, rd_data_o shows the oldest stored byte.
- R3: Capacity is 1 when fifo_en_i is 0, 16 when fifo_en_i is 1 and deep_i is 0, and 64 when fifo_en_i is 1 and deep_i is 1. A write made while count_o is at or above the capacity, with no read in the same cycle, is not stored.
- R4: A write that is not stored sets ovf_o on the next edge. ovf_o then stays 1 until a cycle with stat_rd_i high and no dropped write. A dropped write takes priority over the clear.
- R5: A cycle with both wr_en_i and rd_en_i high on a non-empty queue leaves count_o unchanged, even when the queue is full. The oldest byte is removed and the new byte is appended.
- R6: rd_en_i on an empty queue has no effect on any output.
- R7: With fifo_en_i=1 and deep_i=0, trig_sel_i values 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14.
- R8: With fifo_en_i=1 and deep_i=1, trig_sel_i values 0, 1, 2 and 3 select thresholds of 1, 16, 32 and 56.
- R9: With fifo_en_i=0 the threshold is 1, whatever trig_sel_i is.
- R10: trig_irq_o equals (count_o >= threshold) in the same cycle.
- R11: With rts_auto_i=1, rts_no becomes 1 in the cycle in which count_o reaches the threshold. It becomes 0 again only in the cycle in which count_o reaches 0.
- R12: With rts_auto_i=0, rts_no is 0 from the next cycle onward.
- R13: While rts_no is 1, writes are still stored until count_o reaches the capacity.
- R14: empty_o is 1 exactly when count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Receiver delivers a byte |
| wr_data_i | input | 8 | Byte from the receiver |
| rd_en_i | input | 1 | CPU removes the oldest byte |
| stat_rd_i | input | 1 | Status read; clears the overflow flag |
| fifo_en_i | input | 1 | 1: queue mode, 0: single holding register |
| deep_i | input | 1 | 1: 64-entry capacity, 0: 16-entry capacity |
| trig_sel_i | input | 2 | Threshold selector |
| rts_auto_i | input | 1 | Enables automatic RTS control |
| rd_data_o | output | 8 | Oldest stored byte |
| count_o | output | 7 | Number of stored bytes |
| empty_o | output | 1 | Queue holds no bytes |
| ovf_o | output | 1 | Sticky dropped-byte flag |
| trig_irq_o | output | 1 | Fill count is at or above the threshold |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The checker monitors several properties on every cycle. It confirms that the overflow flag stays set until a status read, that a combined read and write keeps the count, that a read on an empty queue leaves it empty, and that RTS stays off until the queue drains or auto mode is turned off. It also confirms that RTS is on whenever auto mode was off, that the count never exceeds the storage, and that the interrupt never fires while empty_o is high. Other behaviours can only be shown by the bench's scenarios, because the checker does not know the table values or the capacities. These are the exact threshold value for each mode and selector, the arrival order of the data, the capacity limit in each mode, and the cycle at which RTS turns off. The bench covers them by filling to each threshold, by overfilling each capacity, and by a long random mix with mode changes, all compared against a queue model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned DEEP    = 64;
  localparam int unsigned SHALLOW = 16;

  // threshold table, indexed by capacity mode and selector
  function automatic int unsigned thr_lookup(input logic deep, input logic [1:0] sel);
    int unsigned t;
    if (deep) begin
      case (sel)
        2'd0: t = 1;
        2'd1: t = 16;
        2'd2: t = 32;
        default: t = 56;
      endcase
    end else begin
      case (sel)
        2'd0: t = 1;
        2'd1: t = 4;
        2'd2: t = 8;
        default: t = 14;
      endcase
    end
    return t;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nx_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  always_comb begin
    count_nx_o = count_q;
    if (push_i && !pop_i) count_nx_o = count_q + CW'(1);
    if (pop_i && !push_i) count_nx_o = count_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + PW'(1);
      count_q <= count_nx_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned SHALLOW = 16,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en_i,
  input  logic          deep_i,
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] thr_o,
  output logic [CW-1:0] cap_o
);
  import rxf_pkg::*;

  always_comb begin
    if (!fifo_en_i) begin
      thr_o = CW'(1);
      cap_o = CW'(1);
    end else begin
      thr_o = CW'(thr_lookup(deep_i, sel_i));
      cap_o = deep_i ? CW'(DEPTH) : CW'(SHALLOW);
    end
  end
endmodule

// File: rtl/rxf_rts.sv
module rxf_rts #(
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          auto_i,
  input  logic [CW-1:0] count_nx_i,
  input  logic [CW-1:0] thr_i,
  output logic          rts_no
);
  logic off_q;

  // hysteresis: off at threshold, on again only when drained
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  off_q <= 1'b0;
    else if (!auto_i)             off_q <= 1'b0;
    else if (count_nx_i >= thr_i) off_q <= 1'b1;
    else if (count_nx_i == '0)    off_q <= 1'b0;
  end

  assign rts_no = off_q;
endmodule

// File: rtl/rx_fifo_flow.sv
module rx_fifo_flow #(
  parameter int unsigned DW      = rxf_pkg::DW,
  parameter int unsigned DEPTH   = rxf_pkg::DEEP,
  parameter int unsigned SHALLOW = rxf_pkg::SHALLOW,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          stat_rd_i,
  input  logic          fifo_en_i,
  input  logic          deep_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          rts_auto_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          trig_irq_o,
  output logic          rts_no
);
  logic [CW-1:0] thr, cap, count, count_nx;
  logic          is_empty, is_full, push, pop, drop;
  logic          ovf_q;

  rxf_level #(.DEPTH(DEPTH), .SHALLOW(SHALLOW)) u_level (
    .fifo_en_i (fifo_en_i),
    .deep_i    (deep_i),
    .sel_i     (trig_sel_i),
    .thr_o     (thr),
    .cap_o     (cap)
  );

  assign is_empty = (count == '0);
  assign is_full  = (count >= cap);
  assign pop      = rd_en_i && !is_empty;
  // a read in the same cycle frees a slot for the incoming byte
  assign push     = wr_en_i && (!is_full || pop);
  assign drop     = wr_en_i && !push;

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .wdata_i    (wr_data_i),
    .rdata_o    (rd_data_o),
    .count_o    (count),
    .count_nx_o (count_nx)
  );

  rxf_rts #(.CW(CW)) u_rts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_i     (rts_auto_i),
    .count_nx_i (count_nx),
    .thr_i      (thr),
    .rts_no     (rts_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (stat_rd_i) ovf_q <= 1'b0;
  end

  assign count_o    = count;
  assign empty_o    = is_empty;
  assign ovf_o      = ovf_q;
  assign trig_irq_o = (count >= thr);
endmodule

// File: rtl/rx_fifo_flow_chk.sv
module rx_fifo_flow_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          stat_rd_i,
  input logic          rts_auto_i,
  input logic [CW-1:0] count_o,
  input logic          empty_o,
  input logic          ovf_o,
  input logic          trig_irq_o,
  input logic          rts_no
);
  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !stat_rd_i |=> ovf_o);

  p_rw_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && rd_en_i && !empty_o |=> $stable(count_o));

  p_empty_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_en_i && !wr_en_i |=> empty_o);

  p_no_irq_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !trig_irq_o);

  p_rts_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_no && rts_auto_i |=> rts_no || empty_o || !rts_auto_i);

  p_rts_manual_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_auto_i |=> !rts_no);

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

bind rx_fifo_flow rx_fifo_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .stat_rd_i  (stat_rd_i),
  .rts_auto_i (rts_auto_i),
  .count_o    (count_o),
  .empty_o    (empty_o),
  .ovf_o      (ovf_o),
  .trig_irq_o (trig_irq_o),
  .rts_no     (rts_no)
);

// File: tb/sim_rx_fifo_flow.sv
`timescale 1ns/1ps
module sim_rx_fifo_flow;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 0, rd = 0, srd = 0, fen = 1, deep = 0, aut = 0;
  logic [7:0] wd = 0;
  logic [1:0] sel = 0;
  logic [7:0] rdata;
  logic [6:0] cnt;
  logic       empty, ovf, irq, rtsn;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rx_fifo_flow u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_data_i(wd), .rd_en_i(rd),
    .stat_rd_i(srd), .fifo_en_i(fen), .deep_i(deep), .trig_sel_i(sel),
    .rts_auto_i(aut), .rd_data_o(rdata), .count_o(cnt), .empty_o(empty),
    .ovf_o(ovf), .trig_irq_o(irq), .rts_no(rtsn)
  );

  // reference model
  logic [7:0] q[$];
  bit m_ovf = 0, m_off = 0;

  function automatic int thr_of(bit f, bit d, bit [1:0] s);
    if (!f) return 1;
    if (d) return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic int cap_of(bit f, bit d);
    return !f ? 1 : (d ? 64 : 16);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_off = 0;
    end else begin
      bit pop, push;
      pop  = rd && q.size() > 0;
      push = wr && (q.size() < cap_of(fen, deep) || pop);
      if (pop) void'(q.pop_front());
      if (push) q.push_back(wd);
      if (wr && !push) m_ovf = 1;
      else if (srd) m_ovf = 0;
      if (!aut) m_off = 0;
      else if (q.size() >= thr_of(fen, deep, sel)) m_off = 1;
      else if (q.size() == 0) m_off = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      string ttag;
      chk("R3 count", cnt, q.size());
      chk("R14 empty", empty, q.size() == 0);
      if (q.size() > 0) chk("R2 data", rdata, q[0]);
      chk("R4 ovf", ovf, m_ovf);
      ttag = !fen ? "R9 irq" : deep ? "R8 irq" : "R7 irq";
      chk({ttag, " R10"}, irq, q.size() >= thr_of(fen, deep, sel));
      chk(aut ? "R11 rts" : "R12 rts", rtsn, m_off);
    end
  end

  task automatic drv(input bit w, input bit [7:0] d, input bit r, input bit s);
    @(posedge clk); #1;
    wr = w; wd = d; rd = r; srd = s;
  endtask

  task automatic idle();
    drv(0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt, 0); chk("R1 empty", empty, 1); chk("R1 ovf", ovf, 0);
    chk("R1 irq", irq, 0); chk("R1 rts", rtsn, 0);

    // R6 read on empty
    drv(0, 0, 1, 0); idle(); @(negedge clk);
    chk("R6 empty read", cnt, 0); chk("R6 empty flag", empty, 1);

    // shallow, threshold 8, auto RTS: fill past threshold then overfill
    fen = 1; deep = 0; sel = 2; aut = 1;
    for (int i = 0; i < 7; i++) drv(1, 8'h10 + 8'(i), 0, 0);
    idle(); @(negedge clk);
    chk("R7 below thr irq", irq, 0); chk("R11 rts before thr", rtsn, 0);
    drv(1, 8'h17, 0, 0); idle(); @(negedge clk);
    chk("R7 at thr irq", irq, 1); chk("R11 rts off at thr", rtsn, 1);
    for (int i = 0; i < 10; i++) drv(1, 8'h20 + 8'(i), 0, 0);
    idle(); @(negedge clk);
    chk("R13 accepted to full", cnt, 16); chk("R4 ovf set", ovf, 1);
    drv(1, 8'h55, 1, 0); idle(); @(negedge clk);
    chk("R5 full rw count", cnt, 16);
    drv(0, 0, 0, 1); idle(); @(negedge clk);
    chk("R4 ovf cleared", ovf, 0);
    for (int i = 0; i < 15; i++) drv(0, 0, 1, 0);
    idle(); @(negedge clk);
    chk("R11 rts held above 0", rtsn, 1);
    drv(0, 0, 1, 0); idle(); @(negedge clk);
    chk("R11 rts on at empty", rtsn, 0); chk("R14 empty", empty, 1);

    // threshold sweep in both capacity modes
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 4; s++) begin
        int t;
        deep = d[0]; sel = s[1:0];
        t = thr_of(1, deep, sel);
        for (int i = 0; i < t - 1; i++) drv(1, 8'(i * 3 + s), 0, 0);
        idle(); @(negedge clk);
        chk(d ? "R8 below" : "R7 below", irq, 0);
        drv(1, 8'hA5, 0, 0); idle(); @(negedge clk);
        chk(d ? "R8 at" : "R7 at", irq, 1);
        chk("R11 rts at thr", rtsn, 1);
        while (cnt != 0) drv(0, 0, 1, 0);
        idle();
      end
    end

    // deep overfill
    deep = 1;
    for (int i = 0; i < 66; i++) drv(1, 8'(i), 0, 0);
    idle(); @(negedge clk);
    chk("R3 deep cap", cnt, 64); chk("R4 deep ovf", ovf, 1);
    while (cnt != 0) drv(0, 0, 1, 0);
    drv(0, 0, 0, 1);

    // holding-register mode, any selector
    fen = 0; sel = 3;
    drv(1, 8'h3C, 0, 0); drv(1, 8'hC3, 0, 0); idle(); @(negedge clk);
    chk("R3 single cap", cnt, 1); chk("R9 irq", irq, 1); chk("R2 kept first", rdata, 8'h3C);
    chk("R4 single ovf", ovf, 1);
    drv(0, 0, 1, 1); idle();

    // manual RTS
    aut = 0; fen = 1; deep = 0; sel = 0;
    drv(1, 8'h01, 0, 0); idle(); @(negedge clk);
    chk("R12 rts stays on", rtsn, 0);
    drv(0, 0, 1, 0); idle();

    // random mix with mode changes
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        fen = $urandom_range(0, 7) != 0; deep = $urandom_range(0, 1) != 0;
        sel = 2'($urandom_range(0, 3)); aut = $urandom_range(0, 3) != 0;
      end
      drv($urandom_range(0, 99) < ((i / 500) % 2 ? 70 : 35), 8'($urandom),
          $urandom_range(0, 99) < ((i / 500) % 2 ? 30 : 60),
          $urandom_range(0, 19) == 0);
    end
    idle(); @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule